// File: doc/BRIEF.md
# Outlier-Trimmed Moving Average Filter

This block smooths a stream of signed 24-bit converter codes that arrive at a slow rate. It keeps a sliding window of the M most recent accepted samples. Each time a new sample arrives, it drops one copy of the smallest value and one copy of the largest value in the window. It then outputs the mean of the remaining M-2 values. There is one output for every accepted input, so the output rate matches the input rate.

A controller that detects a step in the measured quantity can use the load port to overwrite every window entry with one value in a single cycle. The filter then tracks the new level at once instead of waiting M samples. Two instances can be chained, with the output valid and data of the first driving the input of the second, to give second-order smoothing.

Top module: `trim_avg`

## Requirements
- R1: Each accepted input (`in_valid` high, `load` low) enters the window as its newest entry, and the oldest entry is discarded, so the window always holds the M most recently accepted samples.
- R2: Exactly one instance of the window minimum and one instance of the window maximum are excluded from each average, even when either value occurs more than once.
- R3: The output is the two's-complement sum of the remaining M-2 entries divided by M-2, truncated toward zero (for example, a trimmed sum of -7 with M=8 gives -1).
- R4: An output (`out_valid` high for one cycle) appears on the clock edge that accepts an input once the window is full, and `out_valid` is low in any cycle that follows neither an accepted input nor a load.
- R5: After reset, `out_valid` and `out_data` are zero, and `out_valid` stays low until the M-th accepted sample, whose result is the first output.
- R6: A load (`load` high) writes `load_data` into all M entries, marks the window full, and produces `out_valid` with `out_data` equal to `load_data` on the next cycle.
- R7: When `load` and `in_valid` are high in the same cycle, the load takes effect and the input sample is dropped.
- R8: No intermediate overflow occurs: a window of all most-positive codes (8388607) returns 8388607, and a window of all most-negative codes (-8388608) returns -8388608.
- R9: `out_data` holds its last value between outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | W | Signed input sample |
| load | input | 1 | Overwrite every window entry with `load_data` |
| load_data | input | W | Value written into the window on load |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | W | Signed trimmed mean |

## Verification
The bench builds two instances from the same stimulus: the default window of 8 (divisor 6) and a window of 4, the smallest legal size, where only two entries survive trimming. The 4-entry instance fills earlier and reaches a state where the minimum and maximum are the only distinct values. This puts warm-up boundaries, duplicate extremes and truncation of odd sums within reach in few samples. Full-scale positive and negative windows check the sum width at W=24, and loads are issued both alone and colliding with an input.

// File: rtl/trim_avg.sv
module trim_avg #(
  parameter int W = 24,
  parameter int M = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_data,
  input  logic                load,
  input  logic signed [W-1:0] load_data,
  output logic                out_valid,
  output logic signed [W-1:0] out_data
);
  localparam int SW = W + $clog2(M) + 1;
  localparam int CW = $clog2(M + 1);
  localparam logic [CW-1:0] FULL = CW'(M);
  localparam logic [CW-1:0] LAST = CW'(M - 1);
  localparam logic signed [SW-1:0] DIVS = SW'(M - 2);

  logic signed [W-1:0]  win_q  [M];
  logic signed [W-1:0]  win_nx [M];
  logic [CW-1:0]        cnt_q;
  logic signed [W-1:0]  lo, hi;
  logic signed [SW-1:0] total, trimmed, quo;

  assign win_nx[0] = in_data;
  for (genvar g = 1; g < M; g++) begin : g_shift
    assign win_nx[g] = win_q[g-1];
  end

  always_comb begin
    total = '0;
    lo = win_nx[0];
    hi = win_nx[0];
    for (int i = 0; i < M; i++) begin
      total = total + SW'(win_nx[i]);
      if (win_nx[i] < lo) lo = win_nx[i];
      if (win_nx[i] > hi) hi = win_nx[i];
    end
  end

  assign trimmed = total - SW'(lo) - SW'(hi);
  assign quo = trimmed / DIVS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_valid <= 1'b0;
      out_data <= '0;
      for (int i = 0; i < M; i++) win_q[i] <= '0;
    end else begin
      out_valid <= 1'b0;
      if (load) begin
        for (int i = 0; i < M; i++) win_q[i] <= load_data;
        cnt_q <= FULL;
        out_valid <= 1'b1;
        out_data <= load_data;
      end else if (in_valid) begin
        win_q <= win_nx;
        if (cnt_q != FULL) cnt_q <= cnt_q + CW'(1);
        if (cnt_q >= LAST) begin
          out_valid <= 1'b1;
          out_data <= quo[W-1:0];
        end
      end
    end
  end

  assert_slide_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !load) |=> (win_q[0] == $past(in_data) && win_q[1] == $past(win_q[0])));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !load) |=> !out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !load) |=> $stable(out_data));

  assert_warmup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !load && cnt_q < LAST) |=> !out_valid);

  assert_load_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (out_valid && out_data == $past(load_data)));

  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && in_valid) |=> (win_q[0] == $past(load_data) && win_q[M-1] == $past(load_data)));

  assert_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !load && cnt_q >= LAST) |=> (out_data >= $past(lo) && out_data <= $past(hi)));
endmodule

// File: tb/tb_trim_avg.sv
module tb_trim_avg;
  localparam int W = 24;
  logic clk = 0, rst_n = 0, in_valid = 0, load = 0;
  logic signed [W-1:0] in_data = '0, load_data = '0;
  logic ov [2];
  logic signed [W-1:0] od [2];
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  trim_avg #(.W(W), .M(8)) dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .load(load), .load_data(load_data), .out_valid(ov[0]), .out_data(od[0]));
  trim_avg #(.W(W), .M(4)) dut_m4 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .load(load), .load_data(load_data), .out_valid(ov[1]), .out_data(od[1]));

  int mval [2] = '{8, 4};
  longint mdl [2][16];
  int cnt [2];
  bit ev [2];
  longint hold [2];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint model_q(int k);
    longint s, lo, hi;
    s = 0; lo = mdl[k][0]; hi = mdl[k][0];
    for (int i = 0; i < mval[k]; i++) begin
      s += mdl[k][i];
      if (mdl[k][i] < lo) lo = mdl[k][i];
      if (mdl[k][i] > hi) hi = mdl[k][i];
    end
    return (s - lo - hi) / longint'(mval[k] - 2);
  endfunction

  task automatic check_outs(string tag);
    for (int k = 0; k < 2; k++) begin
      chk(ov[k] == ev[k], {tag, " valid"}, longint'(ov[k]), longint'(ev[k]));
      chk(longint'(od[k]) == hold[k], {tag, " data"}, longint'(od[k]), hold[k]);
    end
  endtask

  task automatic send(longint x, string tag);
    @(negedge clk); in_valid = 1; in_data = W'(x);
    @(negedge clk); in_valid = 0;
    for (int k = 0; k < 2; k++) begin
      for (int i = 15; i > 0; i--) mdl[k][i] = mdl[k][i-1];
      mdl[k][0] = x;
      if (cnt[k] < mval[k]) cnt[k]++;
      ev[k] = (cnt[k] >= mval[k]);
      if (ev[k]) hold[k] = model_q(k);
    end
    check_outs(tag);
  endtask

  task automatic do_load(longint v, bit with_in, longint x, string tag);
    @(negedge clk); load = 1; load_data = W'(v); in_valid = with_in; in_data = W'(x);
    @(negedge clk); load = 0; in_valid = 0;
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 16; i++) mdl[k][i] = v;
      cnt[k] = mval[k]; ev[k] = 1; hold[k] = v;
    end
    check_outs(tag);
  endtask

  task automatic t_reset();
    for (int k = 0; k < 2; k++) begin cnt[k] = 0; ev[k] = 0; hold[k] = 0;
      for (int i = 0; i < 16; i++) mdl[k][i] = 0; end
    check_outs("R5 reset");
  endtask

  task automatic t_warmup();
    for (int i = 0; i < 9; i++) send(longint'(i * 37 - 50), "R5 warmup R1");
  endtask

  task automatic t_pattern();
    longint p [10] = '{1000, -3, 250000, 17, 4096, -77777, 12, 12, 900, -1};
    for (int i = 0; i < 10; i++) send(p[i], "R1 R3 pattern");
    for (int i = 0; i < 8; i++) send(longint'(i * 1000), "R1 ramp");
  endtask

  task automatic t_dups();
    for (int i = 0; i < 8; i++) send(100, "R2 flat");
    send(500, "R2 dup max"); send(500, "R2 dup max");
    send(-500, "R2 dup min"); send(-500, "R2 dup min");
  endtask

  task automatic t_trunc();
    longint p [8] = '{-1, -1, -1, -1, -1, -2, -1, 5};
    for (int i = 0; i < 8; i++) send(p[i], "R3 trunc toward zero");
  endtask

  task automatic t_extremes();
    for (int i = 0; i < 8; i++) send(8388607, "R8 max pos");
    chk(longint'(od[0]) == 8388607, "R8 full scale pos", longint'(od[0]), 8388607);
    for (int i = 0; i < 8; i++) send(-8388608, "R8 max neg");
    chk(longint'(od[0]) == -8388608, "R8 full scale neg", longint'(od[0]), -8388608);
  endtask

  task automatic t_idle();
    for (int k = 0; k < 2; k++) ev[k] = 0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); check_outs("R4 R9 idle hold"); end
  endtask

  task automatic t_load();
    do_load(1234, 0, 0, "R6 load");
    send(1240, "R6 after load");
    send(-20, "R6 after load");
  endtask

  task automatic t_collide();
    do_load(-4321, 1, 777777, "R7 load vs input");
    send(10, "R7 dropped sample absent");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk); check_outs("R5 reset released");
    t_warmup();
    t_pattern();
    t_dups();
    t_trunc();
    t_extremes();
    t_idle();
    t_load();
    t_collide();
    t_idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule